// File: doc/BRIEF.md
# Folded Binary PCM Quantizer and Decoder

This block turns signed linear samples into sign-magnitude PCM words in folded binary form, and it turns such words back into signed levels. Each sample arrives as a two's-complement word counted in quarter steps, which gives two fractional bits below the quantization step. The encoder captures a word on a one-cycle strobe. It rounds the magnitude to the nearest whole step, with exact half-step ties going away from zero, and limits anything beyond the largest level to the top magnitude code. It then puts the sign in the most significant bit of the code.

The decoder path is independent of the encoder. It takes a folded code on its own strobe and produces the signed integer level that a downstream DAC model would output. Both zero codes map to a level of zero. The code width `N` is a parameter and must be at least 2. The input word is `N+2` bits wide. With the default `N = 3`, the levels run from -3 to +3 steps.

Top module: `pcmq_folded`

## Requirements
- R1: After reset, `code_valid` and `lvl_valid` are 0 and `code_out` and `lvl_out` are all zeros. A `smp_valid` strobe in one cycle raises `code_valid` for exactly the next cycle, and in that cycle `code_out` holds the code of the word captured on the strobe.
- R2: Bit N-1 of `code_out` is 1 for a captured input that is zero or positive, and 0 for a negative input. Bits N-2..0 hold the magnitude level.
- R3: The magnitude level is |x|/4 (x being the input in quarter steps) rounded to the nearest integer. A remainder of exactly two quarters rounds up: +2.5 steps gives level 3, and -0.5 steps gives code 001 when N=3.
- R4: An input whose rounded magnitude exceeds 2^(N-1)-1 produces the top magnitude level with the input's sign. With N=3, +3.75 steps gives 111 and -4 steps gives 011.
- R5: An input of exactly zero gives the positive-zero code (1 followed by zeros). A negative input of a quarter step in magnitude gives the negative-zero code (all zeros).
- R6: For every input that is not clipped, the level the code stands for differs from the input by at most half a step (two quarters).
- R7: While `smp_valid` is low, `code_out` keeps its value and `smp_in` has no effect.
- R8: On a `dec_valid` strobe, either zero code (magnitude bits all 0) makes `lvl_out` equal to 0 in the next cycle.
- R9: On a `dec_valid` strobe with a nonzero magnitude m, `lvl_out` in the next cycle is +m if bit N-1 of `dec_code` is 1, and -m if it is 0. `lvl_out` is N-bit two's complement.
- R10: `lvl_valid` is high for exactly the cycle after each `dec_valid` strobe. While `dec_valid` is low, `lvl_out` keeps its value and `dec_code` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| smp_valid | input | 1 | One-cycle strobe that captures `smp_in` |
| smp_in | input | N+2 | Two's-complement sample in quarter steps |
| code_valid | output | 1 | High for the cycle in which a new code is presented |
| code_out | output | N | Folded sign-magnitude code |
| dec_valid | input | 1 | One-cycle strobe that captures `dec_code` |
| dec_code | input | N | Folded code to decode |
| lvl_valid | output | 1 | High for the cycle in which a new level is presented |
| lvl_out | output | N | Signed decoded level in whole steps |

## Verification
The assertions check the following on every cycle: the one-cycle latency of both valid pulses, that both outputs hold between strobes, that the sign bit follows the input polarity, that the half-step error bound is met whenever the input is not clipped, that the clip value is correct, and the zero and sign mapping of the decoder. Only the bench's scenarios show the exact code for each input word. Those include the placement of half-step ties, the split between positive and negative zero, the clipping at both ends of the range, and the fact that input changes between strobes have no effect. The bench does this by sweeping every input word and every code at the default width.

// File: rtl/pcmq_pkg.sv
package pcmq_pkg;

  localparam int unsigned PCMQ_FRAC_BITS = 2;

  function automatic int unsigned pcmq_max_mag(input int unsigned n);
    return (32'd1 << (n - 1)) - 32'd1;
  endfunction

endpackage

// File: rtl/pcmq_rounder.sv
module pcmq_rounder
  import pcmq_pkg::*;
#(
  parameter int unsigned N = 3
) (
  input  logic [N+1:0] x,
  output logic         sgn,
  output logic [N-2:0] mag
);
  localparam int unsigned W       = N + PCMQ_FRAC_BITS;
  localparam int unsigned MAX_MAG = pcmq_max_mag(N);

  logic [W:0] abs_q;
  logic [W:0] rnd_q;
  logic [W:0] lvl_full;

  always_comb begin
    if (x[W-1]) abs_q = {1'b0, ~x} + (W+1)'(1);
    else        abs_q = {1'b0, x};
    rnd_q    = abs_q + (W+1)'(2);
    lvl_full = rnd_q >> PCMQ_FRAC_BITS;
    sgn      = ~x[W-1];
    if (lvl_full > (W+1)'(MAX_MAG)) mag = (N-1)'(MAX_MAG);
    else                            mag = lvl_full[N-2:0];
  end

endmodule

// File: rtl/pcmq_encoder.sv
module pcmq_encoder
  import pcmq_pkg::*;
#(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_valid,
  input  logic [N+1:0] smp_in,
  output logic         code_valid,
  output logic [N-1:0] code_out
);
  localparam int unsigned W       = N + PCMQ_FRAC_BITS;
  localparam int unsigned MAX_MAG = pcmq_max_mag(N);
  localparam int          CLIP_Q  = int'(MAX_MAG) * 4 + 1;

  logic         r_sgn;
  logic [N-2:0] r_mag;
  logic [N-1:0] code_d;
  logic         vld_d;

  pcmq_rounder #(.N(N)) u_round (
    .x   (smp_in),
    .sgn (r_sgn),
    .mag (r_mag)
  );

  always_comb begin
    vld_d  = smp_valid;
    code_d = code_out;
    if (smp_valid) code_d = {r_sgn, r_mag};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_valid <= 1'b0;
      code_out   <= '0;
    end else begin
      code_valid <= vld_d;
      code_out   <= code_d;
    end
  end

  // checking aids: last captured input and level implied by the code
  logic [W-1:0]     seen_x;
  logic signed [W+1:0] code_q;
  logic signed [W+1:0] err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seen_x <= '0;
    else if (smp_valid) seen_x <= smp_in;
  end

  always_comb begin
    if (code_out[N-1]) code_q =  $signed({3'b000, code_out[N-2:0], 2'b00});
    else               code_q = -$signed({3'b000, code_out[N-2:0], 2'b00});
    err_q = code_q - $signed({{2{seen_x[W-1]}}, seen_x});
  end

  a_r1_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> code_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> !code_valid);
  a_r2_sign_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> (code_out[N-1] == !$past(smp_in[W-1])));
  a_r4_clip_high: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && (int'($signed(smp_in)) > CLIP_Q)) |=>
      (code_out == {1'b1, (N-1)'(MAX_MAG)}));
  a_r6_half_step: assert property (@(posedge clk) disable iff (!rst_n)
    (code_valid && (code_out[N-2:0] != (N-1)'(MAX_MAG))) |->
      ((err_q <= 2) && (err_q >= -2)));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(code_out));

endmodule

// File: rtl/pcmq_decoder.sv
module pcmq_decoder #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dec_valid,
  input  logic [N-1:0] dec_code,
  output logic         lvl_valid,
  output logic [N-1:0] lvl_out
);
  logic [N-1:0] mag_ext;
  logic [N-1:0] lvl_d;

  always_comb begin
    mag_ext = {1'b0, dec_code[N-2:0]};
    lvl_d   = lvl_out;
    if (dec_valid) begin
      if (dec_code[N-1]) lvl_d = mag_ext;
      else               lvl_d = (~mag_ext) + N'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_valid <= 1'b0;
      lvl_out   <= '0;
    end else begin
      lvl_valid <= dec_valid;
      lvl_out   <= lvl_d;
    end
  end

  a_r8_zero_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && (dec_code[N-2:0] == '0)) |=> (lvl_out == '0));
  a_r9_sign_map: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && (dec_code[N-2:0] != '0)) |=> (lvl_out[N-1] == !$past(dec_code[N-1])));
  a_r10_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> lvl_valid);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |=> (!lvl_valid && $stable(lvl_out)));

endmodule

// File: rtl/pcmq_folded.sv
module pcmq_folded #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_valid,
  input  logic [N+1:0] smp_in,
  output logic         code_valid,
  output logic [N-1:0] code_out,
  input  logic         dec_valid,
  input  logic [N-1:0] dec_code,
  output logic         lvl_valid,
  output logic [N-1:0] lvl_out
);
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  initial begin
    assert (N >= 2) else $error("pcmq_folded: N must be at least 2");
  end

  pcmq_encoder #(.N(N)) u_enc (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .smp_valid  (smp_valid),
    .smp_in     (smp_in),
    .code_valid (code_valid),
    .code_out   (code_out)
  );

  pcmq_decoder #(.N(N)) u_dec (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .dec_valid (dec_valid),
    .dec_code  (dec_code),
    .lvl_valid (lvl_valid),
    .lvl_out   (lvl_out)
  );

endmodule

// File: tb/tb_pcmq_folded.sv
`timescale 1ns/1ps
module tb_pcmq_folded;
  localparam int N    = 3;
  localparam int W    = N + 2;
  localparam int MAXM = (1 << (N - 1)) - 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         smp_valid;
  logic [W-1:0] smp_in;
  logic         code_valid;
  logic [N-1:0] code_out;
  logic         dec_valid;
  logic [N-1:0] dec_code;
  logic         lvl_valid;
  logic [N-1:0] lvl_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pcmq_folded #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_in(smp_in),
    .code_valid(code_valid), .code_out(code_out), .dec_valid(dec_valid),
    .dec_code(dec_code), .lvl_valid(lvl_valid), .lvl_out(lvl_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int enc_exp(input int xv);
    int a, lvl, s;
    s   = (xv >= 0) ? 1 : 0;
    a   = (xv < 0) ? -xv : xv;
    lvl = (a + 2) / 4;
    if (lvl > MAXM) lvl = MAXM;
    return (s << (N - 1)) | lvl;
  endfunction

  function automatic string enc_tag(input int xv);
    int a;
    a = (xv < 0) ? -xv : xv;
    if ((a + 2) / 4 > MAXM) return "R4";
    if (a % 4 == 2)         return "R3";
    if ((a + 2) / 4 == 0)   return "R5";
    return "R6";
  endfunction

  function automatic int dec_exp(input int c);
    int m;
    m = c & MAXM;
    if (m == 0) return 0;
    return ((c >> (N - 1)) & 1) ? m : -m;
  endfunction

  task automatic enc_one(input int xv);
    int exp;
    exp = enc_exp(xv);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_in    = W'(xv);
    @(negedge clk);
    smp_valid = 1'b0;
    smp_in    = ~W'(xv);
    chk("R1 valid", int'(code_valid), 1);
    chk({enc_tag(xv), " code"}, int'(code_out), exp);
    chk("R2 sign", int'(code_out[N-1]), (xv >= 0) ? 1 : 0);
    @(negedge clk);
    smp_in = W'(xv + 5);
    chk("R1 pulse", int'(code_valid), 0);
    chk("R7 hold", int'(code_out), exp);
  endtask

  task automatic dec_one(input int c);
    @(negedge clk);
    dec_valid = 1'b1;
    dec_code  = N'(c);
    @(negedge clk);
    dec_valid = 1'b0;
    dec_code  = ~N'(c);
    chk("R10 valid", int'(lvl_valid), 1);
    chk(((c & MAXM) == 0) ? "R8 zero" : "R9 level", int'($signed(lvl_out)), dec_exp(c));
    @(negedge clk);
    chk("R10 pulse", int'(lvl_valid), 0);
    chk("R10 hold", int'($signed(lvl_out)), dec_exp(c));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    smp_valid = 1'b0;
    smp_in    = '0;
    dec_valid = 1'b0;
    dec_code  = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset code_valid", int'(code_valid), 0);
    chk("R1 reset code_out", int'(code_out), 0);
    chk("R1 reset lvl_valid", int'(lvl_valid), 0);
    chk("R1 reset lvl_out", int'(lvl_out), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // named corner cases at N=3
    enc_one(0);      chk("R5 plus zero", int'(code_out), 4);
    enc_one(-1);     chk("R5 minus zero", int'(code_out), 0);
    enc_one(-2);     chk("R3 tie negative", int'(code_out), 1);
    enc_one(10);     chk("R3 tie positive", int'(code_out), 7);
    enc_one(15);     chk("R4 clip positive", int'(code_out), 7);
    enc_one(-16);    chk("R4 clip negative", int'(code_out), 3);

    // full sweep of every input word
    for (int xv = -(1 << (W - 1)); xv < (1 << (W - 1)); xv++) enc_one(xv);

    // back-to-back strobes
    @(negedge clk);
    smp_valid = 1'b1; smp_in = W'(8);
    @(negedge clk);
    smp_in = W'(-5);
    chk("R1 b2b first", int'(code_out), enc_exp(8));
    @(negedge clk);
    smp_valid = 1'b0;
    chk("R1 b2b valid", int'(code_valid), 1);
    chk("R1 b2b second", int'(code_out), enc_exp(-5));

    // decoder sweep
    for (int c = 0; c < (1 << N); c++) dec_one(c);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule